// File: doc/BRIEF.md
# Speculative Address Resolution Buffer

This block sits between several ordered processing stages and a data cache. Stages issue loads as soon as an address is known, betting that no earlier stage has a pending store to the same place. Each buffer entry is allocated per address. It holds an address tag and, for each stage, a load mark, a store mark and a data word. A stage's age is its distance from the head pointer, counted modulo the number of stages. The head stage is the oldest and is non-speculative.

A load returns the value from the closest stage at or before its own age that has stored to the address. If no such stage exists, the load returns a miss and the caller reads the data cache. A store stays in the buffer. If a younger stage has already loaded the same address, the store raises a squash naming the oldest such stage, and that stage and every younger one lose their marks in all entries. When the head advances, the retiring stage's stores drain to a cache write port, one per cycle. The retiring stage's load marks are cleared and the head then steps by one. An entry is free once no mark remains in it. A new address that finds no free entry is stalled.

Top module: `spec_arb`

## Requirements
- R1: After reset, head_ptr is 0, rsp_vld, sq_vld and cm_vld are 0, and every load misses.
- R2: An accepted load yields rsp_vld one cycle later. rsp_fwd is 0 when no stage at or before the load's age holds a store mark for the address.
- R3: An accepted load whose address holds store marks at or before its own age returns rsp_fwd=1, with rsp_data from the store of greatest age not exceeding its own, where age = (stage - head_ptr) mod NSTG. This includes the load's own stage.
- R4: Stores from stages younger than the load are never forwarded.
- R5: A store to an address carrying a load mark of a younger stage raises sq_vld one cycle later. sq_stage is the youngest-but-oldest violator, meaning the one of least age among younger stages with a load mark. The head stage is never named.
- R6: On a squash, every entry loses the load and store marks of the named stage and of all stages younger than it. Stores from older stages survive.
- R7: A load by a stage that already stored to the address sets no load mark, so a later older store to it raises no squash.
- R8: Ages wrap with the head: after the head advances, stage 0 becomes the youngest. head_ptr only ever steps by one, modulo NSTG.
- R9: Stores never reach the commit port while speculative. After head_adv, each store mark of the retiring stage appears on cm_vld/cm_addr/cm_data, one per cycle, in ascending slot order. head_ptr increments one cycle after the last commit.
- R10: A request to a new address with no free entry asserts stall in the same cycle and is dropped. A request that hits an existing entry is still served when the buffer is full.
- R11: During a drain every request stalls. A request in the same cycle as head_adv is served with the old head, and a store it makes from the retiring stage is committed in that drain.
- R12: An entry is freed once no load or store mark remains in it, so a drain restores capacity for new addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request valid |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_stage | input | SW | Issuing stage |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Store data |
| stall | output | 1 | Request not accepted this cycle |
| head_adv | input | 1 | Retire the head stage |
| rsp_vld | output | 1 | Load response valid |
| rsp_fwd | output | 1 | 1 = data forwarded from buffer, 0 = read data cache |
| rsp_data | output | DW | Forwarded data |
| sq_vld | output | 1 | Misspeculation detected |
| sq_stage | output | SW | Oldest violating stage to restart |
| head_ptr | output | SW | Current head stage |
| cm_vld | output | 1 | Commit write valid |
| cm_addr | output | AW | Commit address |
| cm_data | output | DW | Commit data |

## Verification
The two functions that share a cycle are a head advance and a store issued by the head stage itself. The store must still be accepted under the old head and must then join the drain that the same edge starts. The bench raises head_adv and the store together while other head-stage stores sit in lower slots. It then expects the commit stream in slot order with the new store last, and expects a load held through the drain to stall every cycle until head_ptr moves.

// File: rtl/spec_arb_pkg.sv
package spec_arb_pkg;
  typedef enum logic [0:0] {
    ARB_RUN   = 1'b0,
    ARB_DRAIN = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/spec_arb_prio.sv
module spec_arb_prio #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spec_arb_lookup.sv
module spec_arb_lookup #(
  parameter int NENT = 8,
  parameter int AW   = 16,
  parameter int IW   = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tags [NENT],
  input  logic [NENT-1:0] occ,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic          any_free,
  output logic [IW-1:0] free_idx
);
  logic [NENT-1:0] hit_vec;

  for (genvar e = 0; e < NENT; e++) begin : g_cmp
    assign hit_vec[e] = occ[e] && (tags[e] == addr);
  end

  spec_arb_prio #(.N(NENT), .IW(IW)) u_hit (
    .vec(hit_vec), .found(hit), .idx(hit_idx)
  );

  spec_arb_prio #(.N(NENT), .IW(IW)) u_free (
    .vec(~occ), .found(any_free), .idx(free_idx)
  );

  // one live entry per address, kept by the allocation logic of the top
  assert_single_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/spec_arb_order.sv
module spec_arb_order #(
  parameter int NSTG = 4,
  parameter int SW   = $clog2(NSTG)
) (
  input  logic [NSTG-1:0] ld_row,
  input  logic [NSTG-1:0] st_row,
  input  logic [SW-1:0]   head,
  input  logic [SW-1:0]   stg,
  output logic            fwd_vld,
  output logic [SW-1:0]   fwd_stg,
  output logic            viol,
  output logic [SW-1:0]   victim
);
  logic [SW-1:0] age_me;
  logic [SW-1:0] s_k;

  assign age_me = stg - head;

  always_comb begin
    fwd_vld = 1'b0;
    fwd_stg = '0;
    viol    = 1'b0;
    victim  = '0;
    s_k     = '0;
    // walk oldest to youngest: last storing stage not younger than the load wins
    for (int k = 0; k < NSTG; k++) begin
      s_k = head + SW'(k);
      if ((SW'(k) <= age_me) && st_row[s_k]) begin
        fwd_vld = 1'b1;
        fwd_stg = s_k;
      end
    end
    // walk youngest to oldest: last younger loader found is the oldest one
    for (int k = NSTG - 1; k >= 0; k--) begin
      s_k = head + SW'(k);
      if ((SW'(k) > age_me) && ld_row[s_k]) begin
        viol   = 1'b1;
        victim = s_k;
      end
    end
  end
endmodule

// File: rtl/spec_arb.sv
module spec_arb
  import spec_arb_pkg::*;
#(
  parameter int NSTG = 4,
  parameter int NENT = 8,
  parameter int AW   = 16,
  parameter int DW   = 32,
  localparam int SW  = $clog2(NSTG),
  localparam int IW  = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic          req_wr,
  input  logic [SW-1:0] req_stage,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          stall,
  input  logic          head_adv,
  output logic          rsp_vld,
  output logic          rsp_fwd,
  output logic [DW-1:0] rsp_data,
  output logic          sq_vld,
  output logic [SW-1:0] sq_stage,
  output logic [SW-1:0] head_ptr,
  output logic          cm_vld,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // state
  logic [AW-1:0]   tag_q [NENT];
  logic [DW-1:0]   dat_q [NENT][NSTG];
  logic [NSTG-1:0] ld_q  [NENT];
  logic [NSTG-1:0] st_q  [NENT];
  logic [SW-1:0]   head_q;
  arb_mode_e       mode_q;
  logic            rsp_vld_q, rsp_fwd_q, sq_vld_q;
  logic [DW-1:0]   rsp_data_q;
  logic [SW-1:0]   sq_stage_q;

  logic [AW-1:0]   tag_d [NENT];
  logic [DW-1:0]   dat_d [NENT][NSTG];
  logic [NSTG-1:0] ld_d  [NENT];
  logic [NSTG-1:0] st_d  [NENT];
  logic [SW-1:0]   head_d;
  arb_mode_e       mode_d;
  logic            rsp_vld_d, rsp_fwd_d, sq_vld_d;
  logic [DW-1:0]   rsp_data_d;
  logic [SW-1:0]   sq_stage_d;

  // occupancy and drain column
  logic [NENT-1:0] occ, dr_vec;
  for (genvar e = 0; e < NENT; e++) begin : g_occ
    assign occ[e]    = |(ld_q[e] | st_q[e]);
    assign dr_vec[e] = st_q[e][head_q];
  end

  // address match and free slot
  logic          hit, any_free;
  logic [IW-1:0] hit_idx, free_idx, slot;

  spec_arb_lookup #(.NENT(NENT), .AW(AW), .IW(IW)) u_lookup (
    .clk(clk), .rst_n(rst_q), .tags(tag_q), .occ(occ), .addr(req_addr),
    .hit(hit), .hit_idx(hit_idx), .any_free(any_free), .free_idx(free_idx)
  );
  assign slot = hit ? hit_idx : free_idx;

  // ordering among stages of the matched entry
  logic [NSTG-1:0] ld_row, st_row;
  logic            fwd_vld, viol;
  logic [SW-1:0]   fwd_stg, victim;
  assign ld_row = ld_q[hit_idx] & {NSTG{hit}};
  assign st_row = st_q[hit_idx] & {NSTG{hit}};

  spec_arb_order #(.NSTG(NSTG), .SW(SW)) u_order (
    .ld_row(ld_row), .st_row(st_row), .head(head_q), .stg(req_stage),
    .fwd_vld(fwd_vld), .fwd_stg(fwd_stg), .viol(viol), .victim(victim)
  );

  // stages at or younger than the victim
  logic [NSTG-1:0] kill;
  logic [SW-1:0]   age_v;
  assign age_v = victim - head_q;
  for (genvar s = 0; s < NSTG; s++) begin : g_kill
    logic [SW-1:0] age_s;
    assign age_s   = SW'(s) - head_q;
    assign kill[s] = age_s >= age_v;
  end

  // drain picker
  logic          dr_found;
  logic [IW-1:0] dr_idx;
  spec_arb_prio #(.N(NENT), .IW(IW)) u_drain (
    .vec(dr_vec), .found(dr_found), .idx(dr_idx)
  );

  logic acc;
  assign stall = req_vld && ((mode_q == ARB_DRAIN) || (!hit && !any_free));
  assign acc   = req_vld && !stall;

  // next state
  always_comb begin
    tag_d      = tag_q;
    dat_d      = dat_q;
    ld_d       = ld_q;
    st_d       = st_q;
    head_d     = head_q;
    mode_d     = mode_q;
    rsp_vld_d  = 1'b0;
    rsp_fwd_d  = 1'b0;
    rsp_data_d = '0;
    sq_vld_d   = 1'b0;
    sq_stage_d = '0;
    if (mode_q == ARB_RUN) begin
      if (acc) begin
        if (!hit) tag_d[slot] = req_addr;
        if (req_wr) begin
          st_d[slot][req_stage]  = 1'b1;
          dat_d[slot][req_stage] = req_wdata;
          if (viol) begin
            sq_vld_d   = 1'b1;
            sq_stage_d = victim;
            for (int e = 0; e < NENT; e++) begin
              ld_d[e] = ld_d[e] & ~kill;
              st_d[e] = st_d[e] & ~kill;
            end
          end
        end else begin
          if (!st_row[req_stage]) ld_d[slot][req_stage] = 1'b1;
          rsp_vld_d  = 1'b1;
          rsp_fwd_d  = fwd_vld;
          rsp_data_d = fwd_vld ? dat_q[hit_idx][fwd_stg] : '0;
        end
      end
      if (head_adv) mode_d = ARB_DRAIN;
    end else begin
      if (dr_found) begin
        st_d[dr_idx][head_q] = 1'b0;
      end else begin
        for (int e = 0; e < NENT; e++) ld_d[e][head_q] = 1'b0;
        head_d = head_q + SW'(1);
        mode_d = ARB_RUN;
      end
    end
  end

  // registers with reset
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int e = 0; e < NENT; e++) begin
        ld_q[e] <= '0;
        st_q[e] <= '0;
      end
      head_q     <= '0;
      mode_q     <= ARB_RUN;
      rsp_vld_q  <= 1'b0;
      rsp_fwd_q  <= 1'b0;
      rsp_data_q <= '0;
      sq_vld_q   <= 1'b0;
      sq_stage_q <= '0;
    end else begin
      ld_q       <= ld_d;
      st_q       <= st_d;
      head_q     <= head_d;
      mode_q     <= mode_d;
      rsp_vld_q  <= rsp_vld_d;
      rsp_fwd_q  <= rsp_fwd_d;
      rsp_data_q <= rsp_data_d;
      sq_vld_q   <= sq_vld_d;
      sq_stage_q <= sq_stage_d;
    end
  end

  // payload storage without reset, written only when the request is taken
  always_ff @(posedge clk) begin
    if (acc) begin
      tag_q <= tag_d;
      dat_q <= dat_d;
    end
  end

  assign rsp_vld  = rsp_vld_q;
  assign rsp_fwd  = rsp_fwd_q;
  assign rsp_data = rsp_data_q;
  assign sq_vld   = sq_vld_q;
  assign sq_stage = sq_stage_q;
  assign head_ptr = head_q;
  assign cm_vld   = (mode_q == ARB_DRAIN) && dr_found;
  assign cm_addr  = tag_q[dr_idx];
  assign cm_data  = dat_q[dr_idx][head_q];

  // assertions
  assert_rsp_from_load_R2: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_vld |-> $past(req_vld && !req_wr && !stall));

  assert_sq_from_store_R5: assert property (@(posedge clk) disable iff (!rst_q)
    sq_vld |-> $past(req_vld && req_wr && !stall));

  assert_sq_not_head_R5: assert property (@(posedge clk) disable iff (!rst_q)
    sq_vld |-> (sq_stage != head_ptr));

  assert_head_step_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (head_ptr != $past(head_ptr)) |-> (head_ptr == $past(head_ptr) + SW'(1)));

  assert_commit_holds_head_R9: assert property (@(posedge clk) disable iff (!rst_q)
    cm_vld |=> $stable(head_ptr));
endmodule

// File: tb/sim_spec_arb.sv
module sim_spec_arb;
  localparam int SW = 2;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_vld = 1'b0, req_wr = 1'b0, head_adv = 1'b0;
  logic [SW-1:0] req_stage = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          stall, rsp_vld, rsp_fwd, sq_vld, cm_vld;
  logic [DW-1:0] rsp_data, cm_data;
  logic [SW-1:0] sq_stage, head_ptr;
  logic [AW-1:0] cm_addr;

  always #2.5 clk = ~clk;

  spec_arb u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_stage(req_stage), .req_addr(req_addr), .req_wdata(req_wdata),
    .stall(stall), .head_adv(head_adv), .rsp_vld(rsp_vld), .rsp_fwd(rsp_fwd),
    .rsp_data(rsp_data), .sq_vld(sq_vld), .sq_stage(sq_stage),
    .head_ptr(head_ptr), .cm_vld(cm_vld), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  int errors = 0, checks = 0;
  logic [DW:0]   rspq [$];
  string         rspt [$];
  logic [AW+DW-1:0] cmq [$];
  logic          sq_seen;
  logic [SW-1:0] sq_stg_seen;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected load responses
  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      if (rspq.size() == 0) begin
        chk(1'b0, "R10 unexpected response", 64'(rsp_data), 64'h0);
      end else begin
        logic [DW:0] e;
        string t;
        e = rspq.pop_front();
        t = rspt.pop_front();
        chk(rsp_fwd == e[DW], {t, " fwd"}, 64'(rsp_fwd), 64'(e[DW]));
        if (e[DW]) chk(rsp_data == e[DW-1:0], {t, " data"}, 64'(rsp_data), 64'(e[DW-1:0]));
      end
    end
  end

  task automatic do_req(input bit wr, input int stg, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit exp_stall, input bit exp_fwd, input logic [DW-1:0] exp_d, input string tag);
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_stage = SW'(stg); req_addr = a; req_wdata = d;
    #1;
    chk(stall == exp_stall, {tag, " stall"}, 64'(stall), 64'(exp_stall));
    if (!exp_stall && !wr) begin
      rspq.push_back({exp_fwd, exp_fwd ? exp_d : 32'h0});
      rspt.push_back(tag);
    end
    @(posedge clk); #1;
    req_vld = 1'b0;
    sq_seen = sq_vld;
    sq_stg_seen = sq_stage;
  endtask

  task automatic chk_sq(input bit ev, input int es, input string tag);
    chk(sq_seen == ev, {tag, " sq_vld"}, 64'(sq_seen), 64'(ev));
    if (ev) chk(sq_stg_seen == SW'(es), {tag, " sq_stage"}, 64'(sq_stg_seen), 64'(es));
  endtask

  task automatic advance(input bit with_st, input int stg, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int exp_head);
    logic [SW-1:0] old;
    old = head_ptr;
    @(negedge clk);
    head_adv = 1'b1;
    if (with_st) begin
      req_vld = 1'b1; req_wr = 1'b1; req_stage = SW'(stg); req_addr = a; req_wdata = d;
      #1;
      chk(stall == 1'b0, "R11 store with head_adv accepted", 64'(stall), 64'h0);
    end
    @(posedge clk); #1;
    head_adv = 1'b0;
    req_vld = 1'b1; req_wr = 1'b0; req_stage = old; req_addr = 16'h0010;
    for (int i = 0; i < 40 && head_ptr == old; i++) begin
      @(negedge clk);
      if (i == 0) chk(stall == 1'b1, "R11 stall during drain", 64'(stall), 64'h1);
      if (cm_vld) begin
        if (cmq.size() == 0) chk(1'b0, "R9 extra commit", 64'(cm_addr), 64'h0);
        else begin
          logic [AW+DW-1:0] e;
          e = cmq.pop_front();
          chk({cm_addr, cm_data} == e, "R9 commit addr/data", 64'({cm_addr, cm_data}), 64'(e));
        end
      end
    end
    req_vld = 1'b0;
    chk(head_ptr == SW'(exp_head), "R8 head step", 64'(head_ptr), 64'(exp_head));
    chk(cmq.size() == 0, "R9 all stores committed", 64'(cmq.size()), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(head_ptr == 0, "R1 head", 64'(head_ptr), 64'h0);
    chk(!rsp_vld && !sq_vld && !cm_vld, "R1 outputs idle", 64'({rsp_vld, sq_vld, cm_vld}), 64'h0);

    // phase A, head = 0
    do_req(0, 2, 16'h0010, 0, 0, 0, 0, "R1 first load misses");
    do_req(0, 3, 16'h0010, 0, 0, 0, 0, "R2 hit without stores");
    do_req(1, 1, 16'h0010, 32'h111, 0, 0, 0, "R5 store");
    chk_sq(1, 2, "R5 oldest younger loader");
    do_req(0, 3, 16'h0010, 0, 0, 1, 32'h111, "R3 forward older");
    do_req(1, 3, 16'h0010, 32'h333, 0, 0, 0, "R5 own-stage store");
    chk_sq(0, 0, "R5 no squash on own load");
    do_req(0, 2, 16'h0010, 0, 0, 1, 32'h111, "R4 younger store hidden");
    do_req(0, 3, 16'h0010, 0, 0, 1, 32'h333, "R3 own store");
    chk(cm_vld == 1'b0, "R9 no commit while speculative", 64'(cm_vld), 64'h0);
    do_req(1, 0, 16'h0010, 32'haaa, 0, 0, 0, "R5 head store");
    chk_sq(1, 2, "R5 squash from head");
    do_req(0, 3, 16'h0010, 0, 0, 1, 32'h111, "R6 younger store cleared");
    do_req(1, 2, 16'h0030, 32'h222, 0, 0, 0, "R7 store");
    do_req(0, 2, 16'h0030, 0, 0, 1, 32'h222, "R7 load own");
    do_req(1, 1, 16'h0030, 32'h121, 0, 0, 0, "R7 older store");
    chk_sq(0, 0, "R7 no squash");

    // head advance with a head-stage store in the same cycle
    cmq.push_back({16'h0010, 32'haaa});
    cmq.push_back({16'h0040, 32'h404});
    advance(1, 0, 16'h0040, 32'h404, 1);

    // phase B, head = 1
    do_req(0, 0, 16'h0030, 0, 0, 1, 32'h222, "R8 wrapped age");
    do_req(0, 1, 16'h0040, 0, 0, 0, 0, "R12 drained entry freed");
    for (int i = 0; i < 5; i++)
      do_req(0, 1, 16'h0050 + 16'(i), 0, 0, 0, 0, "R10 fill");
    do_req(0, 1, 16'h0060, 0, 1, 0, 0, "R10 full new address");
    do_req(0, 1, 16'h0030, 0, 0, 1, 32'h121, "R10 hit when full");
    do_req(0, 2, 16'h0060, 0, 1, 0, 0, "R10 still full");

    cmq.push_back({16'h0010, 32'h111});
    cmq.push_back({16'h0030, 32'h121});
    advance(0, 0, 0, 0, 2);
    do_req(0, 2, 16'h0060, 0, 0, 0, 0, "R12 capacity restored");

    cmq.push_back({16'h0030, 32'h222});
    advance(0, 0, 0, 0, 3);
    advance(0, 0, 0, 0, 0);
    chk(head_ptr == 0, "R8 head wraps to 0", 64'(head_ptr), 64'h0);

    repeat (3) @(negedge clk);
    chk(rspq.size() == 0, "R2 all responses seen", 64'(rspq.size()), 64'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule